// File: doc/BRIEF.md
# Byte-String Memory Operation Engine

This block runs the common C-library string and block-memory routines in hardware, one byte per memory access, over a single byte-wide memory port. A host presents an operation code and three 32-bit operands together with a one-cycle start strobe. The engine then walks memory on its own and ends with a one-cycle done pulse and a 32-bit result.

Six operations are supported. The first four are string compare, block copy, string length and block fill. The fifth copies a string and returns the address where its terminating zero was written. The sixth is a stream-out: it moves 1-, 2- or 4-byte items from an incrementing source to one fixed destination window, as a feed into a data register would need. Copy and fill lengths use only the low 15 bits of the length operand.

The memory answers a read one cycle after the request and takes a write in the cycle it is requested. There is no back-pressure, so the engine never waits on memory.

Top module: `strop_engine`

## Requirements
- R1: After reset, busy, done, memReq and memWe are low and result is zero.
- R2: Operation code 0 (compare) reads the byte at opA+i and then the byte at opB+i, for i = 0, 1, …. It stops at the first i where the opA byte is zero or the two bytes differ. The result is the zero-extended opA byte minus the zero-extended opB byte, modulo 2^32.
- R3: Operation code 1 (copy) handles N = opC[14:0] bytes. For each i from 0 to N-1 in ascending order, it reads opB+i and then writes that byte to opA+i. The result is zero.
- R4: Operation code 2 (length) reads opB+i for ascending i. The result is the index of the first zero byte.
- R5: Operation code 3 (fill) writes opB[7:0] to opA+i for i from 0 to N-1, where N = opC[14:0]. There are no reads, and the result is zero.
- R6: Operation code 4 (copy to terminator) reads opB+i and writes that byte to opA+i until a zero byte has been written. The result is the address opA+i of that zero byte.
- R7: Operation code 5 (stream-out) uses an item size taken from itemSize: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Each item byte k is read from opB+i and written to opA+k, where i is the running byte count. The engine stops at the first item boundary where i ≥ opC, using all 32 bits of opC. The result is zero.
- R8: A read returns data on memRdata in the cycle after its request. Write data and address are valid in the cycle memReq and memWe are both high. No access occurs outside an operation.
- R9: Busy is high from the cycle after start is accepted through the done cycle. Done is a single-cycle pulse. The result is valid with done and is held until the next start.
- R10: A copy or fill with opC[14:0] = 0, or a stream-out with opC = 0, raises done in the first cycle after start and makes no memory access.
- R11: Start is ignored while busy. The running operation's accesses and result are unchanged.
- R12: Operation codes 6 and 7 raise done in the first cycle after start, with result zero and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, accepted when idle |
| opSel | input | 3 | Operation code |
| opA | input | 32 | Destination or first string address |
| opB | input | 32 | Source, second string address or fill value |
| opC | input | 32 | Length operand |
| itemSize | input | 2 | Stream-out item size code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid the cycle after a read request |

## Verification
The embedded assertions watch four things on every cycle. Done must be a single-cycle pulse. The latched operation must not change when start arrives while busy. The byte index may only hold or step by one. Every stream-out write must land inside the first item-sized window at the destination. A zero-length copy is also checked to finish at once. Only the bench's scenarios can show the full behaviour. That covers the ordered sequence of addresses and data for each operation, the compare difference when one string runs out, the 15-bit masking of copy and fill lengths, the rounding of a stream-out up to whole items, and the final memory contents.

// File: rtl/strop_pkg.sv
package strop_pkg;

  localparam int BYTE_W = 8;

  localparam logic [2:0] OP_CMP    = 3'd0;
  localparam logic [2:0] OP_COPY   = 3'd1;
  localparam logic [2:0] OP_LEN    = 3'd2;
  localparam logic [2:0] OP_FILL   = 3'd3;
  localparam logic [2:0] OP_CPYT   = 3'd4;
  localparam logic [2:0] OP_STREAM = 3'd5;

  typedef enum logic [1:0] {
    ADR_A  = 2'd0,
    ADR_B  = 2'd1,
    ADR_WR = 2'd2
  } adrSel_e;

  typedef enum logic [1:0] {
    RES_ZERO = 2'd0,
    RES_DIFF = 2'd1,
    RES_IDX  = 2'd2,
    RES_DST  = 2'd3
  } resSel_e;

  typedef struct packed {
    logic    load;
    logic    incIdx;
    logic    holdByte;
    logic    setResult;
    resSel_e resSel;
    adrSel_e adrSel;
    logic    req;
    logic    we;
    logic    wrFill;
    logic    wrItem;
  } ctlStrobe_t;

  typedef struct packed {
    logic inMaskZero;
    logic inFullZero;
    logic lastMasked;
    logic streamLast;
    logic cmpStop;
    logic rdZero;
  } dpStatus_t;

endpackage

// File: rtl/strop_datapath.sv
module strop_datapath
  import strop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          ctl,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [DATA_W-1:0]   opC,
  input  logic [1:0]          itemSize,
  input  logic [BYTE_W-1:0]   memRdata,
  output dpStatus_t           status,
  output logic [DATA_W-1:0]   memAddr,
  output logic [BYTE_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   result
);

  localparam int ITEM_W = 3;
  localparam int PAD_W  = DATA_W - BYTE_W;
  localparam int EXT_W  = DATA_W + 1 - LEN_W;

  logic [DATA_W-1:0] baseA;
  logic [DATA_W-1:0] baseB;
  logic [LEN_W-1:0]  lenMask;
  logic [DATA_W-1:0] lenFull;
  logic [BYTE_W-1:0] fillByte;
  logic [ITEM_W-1:0] itemMask;
  logic [DATA_W-1:0] idx;
  logic [BYTE_W-1:0] byteHold;
  logic [DATA_W-1:0] resultReg;

  logic [DATA_W:0]   idxNext;
  logic [ITEM_W-1:0] itemMaskIn;
  logic [DATA_W-1:0] wrOffset;
  logic [DATA_W-1:0] diffVal;

  always_comb begin
    unique case (itemSize)
      2'd0:    itemMaskIn = 3'd0;
      2'd1:    itemMaskIn = 3'd1;
      default: itemMaskIn = 3'd3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseA     <= '0;
      baseB     <= '0;
      lenMask   <= '0;
      lenFull   <= '0;
      fillByte  <= '0;
      itemMask  <= '0;
      idx       <= '0;
      byteHold  <= '0;
      resultReg <= '0;
    end else begin
      if (ctl.load) begin
        baseA     <= opA;
        baseB     <= opB;
        lenMask   <= opC[LEN_W-1:0];
        lenFull   <= opC;
        fillByte  <= opB[BYTE_W-1:0];
        itemMask  <= itemMaskIn;
        idx       <= '0;
        resultReg <= '0;
      end else if (ctl.incIdx) begin
        idx <= idx + 1'b1;
      end
      if (ctl.holdByte) begin
        byteHold <= memRdata;
      end
      if (ctl.setResult) begin
        unique case (ctl.resSel)
          RES_DIFF: resultReg <= diffVal;
          RES_IDX:  resultReg <= idx;
          RES_DST:  resultReg <= baseA + idx;
          default:  resultReg <= '0;
        endcase
      end
    end
  end

  assign idxNext  = {1'b0, idx} + 1'b1;
  assign wrOffset = ctl.wrItem ? {{(DATA_W-ITEM_W){1'b0}}, idx[ITEM_W-1:0] & itemMask} : idx;
  assign diffVal  = {{PAD_W{1'b0}}, byteHold} - {{PAD_W{1'b0}}, memRdata};

  always_comb begin
    unique case (ctl.adrSel)
      ADR_A:   memAddr = baseA + idx;
      ADR_B:   memAddr = baseB + idx;
      ADR_WR:  memAddr = baseA + wrOffset;
      default: memAddr = baseA;
    endcase
  end

  assign memWdata = ctl.wrFill ? fillByte : memRdata;
  assign result   = resultReg;

  assign status.inMaskZero = (opC[LEN_W-1:0] == '0);
  assign status.inFullZero = (opC == '0);
  assign status.lastMasked = (idxNext == {{EXT_W{1'b0}}, lenMask});
  assign status.streamLast = ((idxNext[ITEM_W-1:0] & itemMask) == '0) &&
                             (idxNext >= {1'b0, lenFull});
  assign status.cmpStop    = (byteHold == '0) || (byteHold != memRdata);
  assign status.rdZero     = (memRdata == '0);

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.load) |-> (idx == $past(idx)) || (idx == $past(idx) + 1'b1));

  // R7
  stream_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.req && ctl.we && ctl.wrItem) |-> ((memAddr - baseA) <= 32'd3));

endmodule

// File: rtl/strop_control.sv
module strop_control
  import strop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opSel,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_RDA, S_RDB, S_CMPE, S_CPYR, S_CPYW, S_LENR, S_LENE,
    S_FILW, S_TRMR, S_TRMW, S_STRR, S_STRW, S_FIN
  } state_e;

  state_e     state;
  state_e     stateNext;
  logic [2:0] opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      opReg <= '0;
    end else begin
      state <= stateNext;
      if (state == S_IDLE && start) begin
        opReg <= opSel;
      end
    end
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    ctl.adrSel = ADR_A;
    ctl.resSel = RES_ZERO;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          unique case (opSel)
            OP_CMP:    stateNext = S_RDA;
            OP_COPY:   stateNext = status.inMaskZero ? S_FIN : S_CPYR;
            OP_LEN:    stateNext = S_LENR;
            OP_FILL:   stateNext = status.inMaskZero ? S_FIN : S_FILW;
            OP_CPYT:   stateNext = S_TRMR;
            OP_STREAM: stateNext = status.inFullZero ? S_FIN : S_STRR;
            default:   stateNext = S_FIN;
          endcase
        end
      end
      S_RDA: begin
        ctl.req    = 1'b1;
        ctl.adrSel = ADR_A;
        stateNext  = S_RDB;
      end
      S_RDB: begin
        ctl.req      = 1'b1;
        ctl.adrSel   = ADR_B;
        ctl.holdByte = 1'b1;
        stateNext    = S_CMPE;
      end
      S_CMPE: begin
        if (status.cmpStop) begin
          ctl.setResult = 1'b1;
          ctl.resSel    = RES_DIFF;
          stateNext     = S_FIN;
        end else begin
          ctl.incIdx = 1'b1;
          stateNext  = S_RDA;
        end
      end
      S_CPYR: begin
        ctl.req    = 1'b1;
        ctl.adrSel = ADR_B;
        stateNext  = S_CPYW;
      end
      S_CPYW: begin
        ctl.req    = 1'b1;
        ctl.we     = 1'b1;
        ctl.adrSel = ADR_WR;
        if (status.lastMasked) begin
          stateNext = S_FIN;
        end else begin
          ctl.incIdx = 1'b1;
          stateNext  = S_CPYR;
        end
      end
      S_LENR: begin
        ctl.req    = 1'b1;
        ctl.adrSel = ADR_B;
        stateNext  = S_LENE;
      end
      S_LENE: begin
        if (status.rdZero) begin
          ctl.setResult = 1'b1;
          ctl.resSel    = RES_IDX;
          stateNext     = S_FIN;
        end else begin
          ctl.incIdx = 1'b1;
          stateNext  = S_LENR;
        end
      end
      S_FILW: begin
        ctl.req    = 1'b1;
        ctl.we     = 1'b1;
        ctl.wrFill = 1'b1;
        ctl.adrSel = ADR_WR;
        if (status.lastMasked) begin
          stateNext = S_FIN;
        end else begin
          ctl.incIdx = 1'b1;
        end
      end
      S_TRMR: begin
        ctl.req    = 1'b1;
        ctl.adrSel = ADR_B;
        stateNext  = S_TRMW;
      end
      S_TRMW: begin
        ctl.req    = 1'b1;
        ctl.we     = 1'b1;
        ctl.adrSel = ADR_WR;
        if (status.rdZero) begin
          ctl.setResult = 1'b1;
          ctl.resSel    = RES_DST;
          stateNext     = S_FIN;
        end else begin
          ctl.incIdx = 1'b1;
          stateNext  = S_TRMR;
        end
      end
      S_STRR: begin
        ctl.req    = 1'b1;
        ctl.adrSel = ADR_B;
        stateNext  = S_STRW;
      end
      S_STRW: begin
        ctl.req    = 1'b1;
        ctl.we     = 1'b1;
        ctl.wrItem = 1'b1;
        ctl.adrSel = ADR_WR;
        if (status.streamLast) begin
          stateNext = S_FIN;
        end else begin
          ctl.incIdx = 1'b1;
          stateNext  = S_STRR;
        end
      end
      S_FIN: begin
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(opReg));

  // R10
  zero_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && (opSel == OP_COPY) && status.inMaskZero) |=> done);

endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  input  logic [1:0]        itemSize,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata,
  input  logic [BYTE_W-1:0] memRdata
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  strop_control ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opSel  (opSel),
    .status (status),
    .ctl    (ctl),
    .busy   (busy),
    .done   (done)
  );

  strop_datapath #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .opA      (opA),
    .opB      (opB),
    .opC      (opC),
    .itemSize (itemSize),
    .memRdata (memRdata),
    .status   (status),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .result   (result)
  );

  assign memReq = ctl.req;
  assign memWe  = ctl.we;

endmodule

// File: tb/strop_engine_tb_top.sv
`timescale 1ns/100ps
module strop_engine_tb_top;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [7:0]  data;
  } acc_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] opA = '0, opB = '0, opC = '0;
  logic [1:0]  itemSize = '0;
  logic        busy, done, memReq, memWe;
  logic [31:0] result, memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;

  logic        ldEn = 1'b0;
  logic [9:0]  ldAddr = '0;
  logic [7:0]  ldData = '0;
  logic [7:0]  memArr [0:1023];
  logic [7:0]  refMem [0:1023];

  acc_t        expQ[$];
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;
  int          startCyc = 0;
  int          doneCyc = 0;
  bit          inFlight = 0;
  bit          doneSeen = 0;
  string       curReq = "R1";

  always #2.5 clk = ~clk;

  strop_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .opA(opA), .opB(opB), .opC(opC), .itemSize(itemSize),
    .busy(busy), .done(done), .result(result),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ldEn) memArr[ldAddr] <= ldData;
    else if (memReq) begin
      if (memWe) memArr[memAddr[9:0]] <= memWdata;
      else memRdata <= memArr[memAddr[9:0]];
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (memReq) begin
        checks++;
        if (!inFlight || expQ.size() == 0) begin
          errors++;
          $display("FAIL R8 unexpected access addr=%h we=%0d expected none", memAddr, memWe);
        end else begin
          acc_t e;
          e = expQ.pop_front();
          if (e.we !== memWe || e.addr !== memAddr || (e.we && e.data !== memWdata)) begin
            errors++;
            $display("FAIL %s access we=%0d addr=%h data=%h expected we=%0d addr=%h data=%h",
                     curReq, memWe, memAddr, memWdata, e.we, e.addr, e.data);
          end
        end
      end
      if (inFlight && !done && !busy) begin
        checks++;
        errors++;
        $display("FAIL R9 busy=%0d expected 1", busy);
      end
      if (done) begin
        doneSeen = 1;
        doneCyc = cyc;
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(int addr, logic [7:0] v);
    refMem[addr] = v;
    @(posedge clk); #1;
    ldEn = 1; ldAddr = addr[9:0]; ldData = v;
    @(posedge clk); #1;
    ldEn = 0;
  endtask

  task automatic putStr(int addr, string s);
    for (int i = 0; i < s.len(); i++) poke(addr + i, s[i]);
    poke(addr + s.len(), 8'h00);
  endtask

  function automatic void pushAcc(logic we, logic [31:0] addr, logic [7:0] data);
    acc_t e;
    e.we = we; e.addr = addr; e.data = data;
    expQ.push_back(e);
  endfunction

  function automatic logic [31:0] model(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                                        logic [31:0] c, logic [1:0] sz);
    logic [31:0] res = 0;
    logic [7:0]  x, y;
    int          n, itemB, i;
    case (op)
      3'd0: begin
        i = 0;
        forever begin
          x = refMem[(a + i) & 1023]; pushAcc(0, a + i, 0);
          y = refMem[(b + i) & 1023]; pushAcc(0, b + i, 0);
          if (x == 0 || x != y) begin
            res = {24'd0, x} - {24'd0, y};
            break;
          end
          i++;
        end
      end
      3'd1: begin
        n = int'(c & 32'h7fff);
        for (int k = 0; k < n; k++) begin
          x = refMem[(b + k) & 1023]; pushAcc(0, b + k, 0);
          refMem[(a + k) & 1023] = x; pushAcc(1, a + k, x);
        end
      end
      3'd2: begin
        i = 0;
        forever begin
          x = refMem[(b + i) & 1023]; pushAcc(0, b + i, 0);
          if (x == 0) begin res = i; break; end
          i++;
        end
      end
      3'd3: begin
        n = int'(c & 32'h7fff);
        for (int k = 0; k < n; k++) begin
          refMem[(a + k) & 1023] = b[7:0]; pushAcc(1, a + k, b[7:0]);
        end
      end
      3'd4: begin
        i = 0;
        forever begin
          x = refMem[(b + i) & 1023]; pushAcc(0, b + i, 0);
          refMem[(a + i) & 1023] = x; pushAcc(1, a + i, x);
          if (x == 0) begin res = a + i; break; end
          i++;
        end
      end
      3'd5: begin
        itemB = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        i = 0;
        while (32'(i) < c) begin
          for (int k = 0; k < itemB; k++) begin
            x = refMem[(b + i) & 1023]; pushAcc(0, b + i, 0);
            refMem[(a + k) & 1023] = x; pushAcc(1, a + k, x);
            i++;
          end
        end
      end
      default: res = 0;
    endcase
    return res;
  endfunction

  task automatic runOp(string req, logic [2:0] op, logic [31:0] a, logic [31:0] b,
                       logic [31:0] c, logic [1:0] sz, bit zeroLat, bit pokeStart);
    logic [31:0] expRes;
    int          waitCnt;
    curReq = req;
    expQ.delete();
    expRes = model(op, a, b, c, sz);
    doneSeen = 0;
    @(posedge clk); #1;
    start = 1; opSel = op; opA = a; opB = b; opC = c; itemSize = sz;
    @(posedge clk); #1;
    start = 0;
    startCyc = cyc;
    inFlight = 1;
    if (pokeStart) begin
      start = 1; opSel = 3'd3; opA = 32'h3f0; opB = 32'h55; opC = 32'd4;
      @(posedge clk); #1;
      @(posedge clk); #1;
      start = 0;
    end
    waitCnt = 0;
    while (!doneSeen) begin
      @(posedge clk); #1;
      waitCnt++;
      if (waitCnt > 5000) begin
        errors++;
        $display("FAIL %s watchdog: done not seen", req);
        finishRun();
      end
    end
    inFlight = 0;
    check(req, result, expRes);
    check(req, expQ.size(), 0);
    if (zeroLat) check("R10", doneCyc - startCyc, 0);
    @(negedge clk);
    check("R9", {30'd0, busy, done}, 0);
    check("R9", result, expRes);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin
      memArr[i] = 8'h00;
      refMem[i] = 8'h00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {29'd0, busy, done, memReq}, 0);
    check("R1", {31'd0, memWe}, 0);
    check("R1", result, 0);
    @(posedge clk); #1;
    rstN = 1;
    for (int i = 0; i < 64; i++) poke(32'h280 + i, 8'(i * 37 + 11));

    putStr(32'h100, "abc"); putStr(32'h110, "abc");
    runOp("R2", 3'd0, 32'h100, 32'h110, 0, 0, 0, 0);
    putStr(32'h120, "abd");
    runOp("R2", 3'd0, 32'h120, 32'h110, 0, 0, 0, 0);
    putStr(32'h130, "ab"); putStr(32'h140, "abz");
    runOp("R2", 3'd0, 32'h130, 32'h140, 0, 0, 0, 0);

    runOp("R3", 3'd1, 32'h200, 32'h280, 32'd5, 0, 0, 0);
    runOp("R3", 3'd1, 32'h210, 32'h288, 32'h0001_0003, 0, 0, 0);
    runOp("R10", 3'd1, 32'h220, 32'h280, 32'h0000_8000, 0, 1, 0);

    putStr(32'h150, "hello");
    runOp("R4", 3'd2, 0, 32'h150, 0, 0, 0, 0);
    poke(32'h160, 8'h00);
    runOp("R4", 3'd2, 0, 32'h160, 0, 0, 0, 0);

    runOp("R5", 3'd3, 32'h230, 32'h1a5, 32'd4, 0, 0, 0);
    runOp("R10", 3'd3, 32'h230, 32'h77, 32'h0002_0000, 0, 1, 0);

    putStr(32'h170, "xyz");
    runOp("R6", 3'd4, 32'h240, 32'h170, 0, 0, 0, 0);

    runOp("R7", 3'd5, 32'h300, 32'h280, 32'd3, 2'd0, 0, 0);
    runOp("R7", 3'd5, 32'h310, 32'h290, 32'd3, 2'd1, 0, 0);
    runOp("R7", 3'd5, 32'h320, 32'h284, 32'd8, 2'd2, 0, 0);
    runOp("R7", 3'd5, 32'h330, 32'h298, 32'd4, 2'd3, 0, 0);
    runOp("R10", 3'd5, 32'h340, 32'h280, 32'd0, 2'd2, 1, 0);

    runOp("R12", 3'd6, 32'h100, 32'h110, 32'd9, 0, 1, 0);
    runOp("R12", 3'd7, 32'h100, 32'h110, 32'd9, 0, 1, 0);

    runOp("R11", 3'd1, 32'h350, 32'h280, 32'd6, 0, 0, 1);

    begin
      int bad = 0;
      for (int i = 0; i < 1024; i++) if (memArr[i] !== refMem[i]) bad++;
      check("R8", bad, 0);
    end
    finishRun();
  end

  initial begin
    #900000;
    errors++;
    $display("FAIL R9 global watchdog expired");
    finishRun();
  end

endmodule